// File: doc/BRIEF.md
# Paged Address Translation and Access Router

This block sits between an 8-bit processor that issues 16-bit logical addresses and a 21-bit physical memory space. It holds eight page-map registers, each 8 bits wide. Logical address bits [15:13] pick one of these registers, and the register supplies a bank number. The physical address is that bank placed above the 13-bit in-page offset, so each page is 8 KB. The processor loads the registers through a write strobe and reads them back through a separate read port.

Each access goes to one of three places, decided by the bank number it selects. One reserved bank value sends the access to an internal I/O register port and addresses that port with the offset alone. A second reserved value marks a save-memory bank. In that bank, writes land only in the lowest 2 KB and are not mirrored into the rest of the page. Every other bank is ordinary memory, and a write reaches it only if a per-bank writable table allows it. The block also holds the interrupt-request state: each source has an active flag, and the processor sees it as pending only when the matching disable bit is low.

Top module: `page_xlate_unit`

## Requirements
- R1: Logical address bits [15:13] select a page-map register. For a memory access, `mem_addr` equals {selected bank[7:0], logical address[12:0]}.
- R2: A page-map register is loaded on the rising clock edge when `map_we` is high. `map_wsel` chooses the register and `map_wdata` gives the value. `map_rdata` shows the register chosen by `map_rsel` without delay. After reset, register 0 holds 0xFF and registers 1 to 7 hold 0x00.
- R3: When the selected bank is 0xFF, `io_rd` and `io_wr` follow the access strobes and `io_addr` equals logical address[12:0]. `acc_rdata` equals `io_rdata`. `mem_rd` and `mem_wr` stay low.
- R4: When the selected bank is 0xF7, `mem_wr` is asserted for a write only if `save_present` is high and the offset is at most 0x7FF. A write at any higher offset produces no memory write.
- R5: For any other bank, `mem_wr` follows `acc_wr` only if that bank's writable bit is set. The writable bit is loaded on the clock edge through `wp_we`, `wp_bank` and `wp_flag`. Every writable bit is clear after reset.
- R6: Each interrupt source has an active flag. An `irq_set` bit sets it, an `irq_clr` bit clears it, and set wins when both are high in the same cycle. `irq_pending` equals active AND NOT `irq_disable`, and it is zero after reset.
- R7: `irq_hit` is high only when the source chosen by `irq_qsel` is both active and not disabled.
- R8: A read from any bank other than 0xFF, including 0xF7, raises `mem_rd` with the full 13-bit offset, and `acc_rdata` then equals `mem_rdata`. `mem_wdata` always equals `acc_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_we | input | 1 | Page-map register load strobe |
| map_wsel | input | 3 | Register to load |
| map_wdata | input | 8 | Bank value to load |
| map_rsel | input | 3 | Register to read back |
| map_rdata | output | 8 | Read-back value |
| wp_we | input | 1 | Writable-table load strobe |
| wp_bank | input | 8 | Bank whose writable bit is loaded |
| wp_flag | input | 1 | Writable bit value |
| save_present | input | 1 | Save memory is fitted |
| acc_addr | input | 16 | Logical address |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data returned to the processor |
| mem_addr | output | 21 | Physical memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| io_addr | output | 13 | I/O register offset |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data |
| irq_set | input | 3 | Per-source set requests |
| irq_clr | input | 3 | Per-source clear strobes |
| irq_disable | input | 3 | Per-source disable mask |
| irq_qsel | input | 2 | Source to query |
| irq_pending | output | 3 | Active and not disabled |
| irq_hit | output | 1 | Query result for the chosen source |

## Verification
The assertions assume that `acc_rd` and `acc_wr` are never high together and that the set, clear and mask inputs stay at zero while reset is held. The bench drives every input on the falling edge and issues one access per cycle with a single strobe. During reset it holds all strobes low, so the properties that look one cycle back only ever see defined values. Random addresses are spread over all eight page registers after those registers have been loaded with the reserved values, so both special banks and ordinary banks are covered.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
   typedef enum logic [1:0] {
      RT_MEM  = 2'd0,
      RT_IO   = 2'd1,
      RT_SAVE = 2'd2
   } route_e;
endpackage

// File: rtl/pxu_map_file.sv
module pxu_map_file #(
   parameter int          NREG      = 8,
   parameter int          BANK_W    = 8,
   parameter int          SEL_W     = 3,
   parameter logic [7:0]  RST_FIRST = 8'hFF,
   parameter logic [7:0]  RST_REST  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [BANK_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [BANK_W-1:0] rdata,
   input  logic [SEL_W-1:0]  xsel,
   output logic [BANK_W-1:0] xbank
);
   if (NREG != (1 << SEL_W)) begin : g_chk_nreg
      $error("pxu_map_file: NREG must equal 2**SEL_W");
   end

   logic [BANK_W-1:0] regs_q [NREG];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      localparam logic [BANK_W-1:0] RST_V = (gi == 0) ? BANK_W'(RST_FIRST) : BANK_W'(RST_REST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[gi] <= RST_V;
         else if (we && (wsel == SEL_W'(gi)))
            regs_q[gi] <= wdata;
      end
   end

   assign rdata = regs_q[rsel];
   assign xbank = regs_q[xsel];
endmodule

// File: rtl/pxu_wr_table.sv
module pxu_wr_table #(
   parameter int BANK_W    = 8,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_we,
   input  logic [BANK_W-1:0] wp_bank,
   input  logic              wp_flag,
   input  logic [BANK_W-1:0] look_bank,
   output logic              look_ok
);
   localparam int NBANK = 1 << BANK_W;

   if (USE_TABLE) begin : g_table
      logic [NBANK-1:0] flags_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_q <= '0;
         else if (wp_we)
            flags_q[wp_bank] <= wp_flag;
      end
      assign look_ok = flags_q[look_bank];
   end else begin : g_all_open
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wp_we, wp_bank, wp_flag, look_bank};
      assign look_ok   = 1'b1;
   end
endmodule

// File: rtl/pxu_router.sv
module pxu_router
   import pxu_pkg::*;
#(
   parameter int          BANK_W     = 8,
   parameter int          PAGE_BITS  = 13,
   parameter int          DATA_W     = 8,
   parameter logic [7:0]  IO_BANK    = 8'hFF,
   parameter logic [7:0]  SAVE_BANK  = 8'hF7,
   parameter int          SAVE_BYTES = 2048
) (
   input  logic [BANK_W-1:0]           bank,
   input  logic [PAGE_BITS-1:0]        offset,
   input  logic                        acc_rd,
   input  logic                        acc_wr,
   input  logic [DATA_W-1:0]           acc_wdata,
   output logic [DATA_W-1:0]           acc_rdata,
   input  logic                        bank_writable,
   input  logic                        save_present,
   output logic [BANK_W+PAGE_BITS-1:0] mem_addr,
   output logic                        mem_rd,
   output logic                        mem_wr,
   output logic [DATA_W-1:0]           mem_wdata,
   input  logic [DATA_W-1:0]           mem_rdata,
   output logic [PAGE_BITS-1:0]        io_addr,
   output logic                        io_rd,
   output logic                        io_wr,
   output logic [DATA_W-1:0]           io_wdata,
   input  logic [DATA_W-1:0]           io_rdata
);
   localparam int PAGE_BYTES = 1 << PAGE_BITS;

   if (SAVE_BYTES > PAGE_BYTES || SAVE_BYTES < 1) begin : g_chk_save
      $error("pxu_router: SAVE_BYTES must fit within one page");
   end
   if (IO_BANK == SAVE_BANK) begin : g_chk_codes
      $error("pxu_router: the I/O and save bank codes must differ");
   end

   route_e route;
   logic   save_in_range;
   logic   wr_allowed;

   always_comb begin
      if (bank == BANK_W'(IO_BANK))
         route = RT_IO;
      else if (bank == BANK_W'(SAVE_BANK))
         route = RT_SAVE;
      else
         route = RT_MEM;
   end

   assign save_in_range = ({1'b0, offset} < (PAGE_BITS+1)'(SAVE_BYTES));

   always_comb begin
      case (route)
         RT_SAVE: wr_allowed = save_present && save_in_range;
         RT_MEM:  wr_allowed = bank_writable;
         default: wr_allowed = 1'b0;
      endcase
   end

   assign mem_addr  = {bank, offset};
   assign mem_rd    = acc_rd && (route != RT_IO);
   assign mem_wr    = acc_wr && wr_allowed;
   assign mem_wdata = acc_wdata;

   assign io_addr   = offset;
   assign io_rd     = acc_rd && (route == RT_IO);
   assign io_wr     = acc_wr && (route == RT_IO);
   assign io_wdata  = acc_wdata;

   assign acc_rdata = (route == RT_IO) ? io_rdata : mem_rdata;
endmodule

// File: rtl/pxu_irq_ctrl.sv
module pxu_irq_ctrl #(
   parameter int NUM_IRQ = 3,
   parameter int QSEL_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_set,
   input  logic [NUM_IRQ-1:0] irq_clr,
   input  logic [NUM_IRQ-1:0] irq_disable,
   input  logic [QSEL_W-1:0]  irq_qsel,
   output logic [NUM_IRQ-1:0] irq_pending,
   output logic               irq_hit
);
   if ((1 << QSEL_W) < NUM_IRQ) begin : g_chk_qsel
      $error("pxu_irq_ctrl: QSEL_W too narrow for NUM_IRQ");
   end

   logic [NUM_IRQ-1:0] active_q;

   for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            active_q[gi] <= 1'b0;
         else if (irq_set[gi])
            active_q[gi] <= 1'b1;
         else if (irq_clr[gi])
            active_q[gi] <= 1'b0;
      end
   end

   assign irq_pending = active_q & ~irq_disable;

   always_comb begin
      irq_hit = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++)
         if (irq_qsel == QSEL_W'(i))
            irq_hit = irq_pending[i];
   end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
   parameter int          LOG_AW     = 16,
   parameter int          PAGE_BITS  = 13,
   parameter int          BANK_W     = 8,
   parameter int          DATA_W     = 8,
   parameter int          NUM_IRQ    = 3,
   parameter int          QSEL_W     = 2,
   parameter logic [7:0]  IO_BANK    = 8'hFF,
   parameter logic [7:0]  SAVE_BANK  = 8'hF7,
   parameter int          SAVE_BYTES = 2048,
   parameter bit          USE_TABLE  = 1'b1,
   localparam int         SEL_W      = LOG_AW - PAGE_BITS,
   localparam int         PHYS_W     = BANK_W + PAGE_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               map_we,
   input  logic [SEL_W-1:0]   map_wsel,
   input  logic [BANK_W-1:0]  map_wdata,
   input  logic [SEL_W-1:0]   map_rsel,
   output logic [BANK_W-1:0]  map_rdata,
   input  logic               wp_we,
   input  logic [BANK_W-1:0]  wp_bank,
   input  logic               wp_flag,
   input  logic               save_present,
   input  logic [LOG_AW-1:0]  acc_addr,
   input  logic               acc_rd,
   input  logic               acc_wr,
   input  logic [DATA_W-1:0]  acc_wdata,
   output logic [DATA_W-1:0]  acc_rdata,
   output logic [PHYS_W-1:0]  mem_addr,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [PAGE_BITS-1:0] io_addr,
   output logic               io_rd,
   output logic               io_wr,
   output logic [DATA_W-1:0]  io_wdata,
   input  logic [DATA_W-1:0]  io_rdata,
   input  logic [NUM_IRQ-1:0] irq_set,
   input  logic [NUM_IRQ-1:0] irq_clr,
   input  logic [NUM_IRQ-1:0] irq_disable,
   input  logic [QSEL_W-1:0]  irq_qsel,
   output logic [NUM_IRQ-1:0] irq_pending,
   output logic               irq_hit
);
   localparam int NREG = 1 << SEL_W;

   if (SEL_W < 1) begin : g_chk_sel
      $error("page_xlate_unit: LOG_AW must exceed PAGE_BITS");
   end
   if (BANK_W < 8) begin : g_chk_bank
      $error("page_xlate_unit: BANK_W must hold the reserved bank codes");
   end

   logic [SEL_W-1:0]     page_sel;
   logic [PAGE_BITS-1:0] page_off;
   logic [BANK_W-1:0]    cur_bank;
   logic                 cur_writable;

   assign page_sel = acc_addr[LOG_AW-1:PAGE_BITS];
   assign page_off = acc_addr[PAGE_BITS-1:0];

   pxu_map_file #(
      .NREG      (NREG),
      .BANK_W    (BANK_W),
      .SEL_W     (SEL_W),
      .RST_FIRST (IO_BANK),
      .RST_REST  (8'h00)
   ) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (map_we),
      .wsel  (map_wsel),
      .wdata (map_wdata),
      .rsel  (map_rsel),
      .rdata (map_rdata),
      .xsel  (page_sel),
      .xbank (cur_bank)
   );

   pxu_wr_table #(
      .BANK_W    (BANK_W),
      .USE_TABLE (USE_TABLE)
   ) u_wrt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wp_we     (wp_we),
      .wp_bank   (wp_bank),
      .wp_flag   (wp_flag),
      .look_bank (cur_bank),
      .look_ok   (cur_writable)
   );

   pxu_router #(
      .BANK_W     (BANK_W),
      .PAGE_BITS  (PAGE_BITS),
      .DATA_W     (DATA_W),
      .IO_BANK    (IO_BANK),
      .SAVE_BANK  (SAVE_BANK),
      .SAVE_BYTES (SAVE_BYTES)
   ) u_route (
      .bank          (cur_bank),
      .offset        (page_off),
      .acc_rd        (acc_rd),
      .acc_wr        (acc_wr),
      .acc_wdata     (acc_wdata),
      .acc_rdata     (acc_rdata),
      .bank_writable (cur_writable),
      .save_present  (save_present),
      .mem_addr      (mem_addr),
      .mem_rd        (mem_rd),
      .mem_wr        (mem_wr),
      .mem_wdata     (mem_wdata),
      .mem_rdata     (mem_rdata),
      .io_addr       (io_addr),
      .io_rd         (io_rd),
      .io_wr         (io_wr),
      .io_wdata      (io_wdata),
      .io_rdata      (io_rdata)
   );

   pxu_irq_ctrl #(
      .NUM_IRQ (NUM_IRQ),
      .QSEL_W  (QSEL_W)
   ) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_set     (irq_set),
      .irq_clr     (irq_clr),
      .irq_disable (irq_disable),
      .irq_qsel    (irq_qsel),
      .irq_pending (irq_pending),
      .irq_hit     (irq_hit)
   );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
   parameter int         LOG_AW     = 16,
   parameter int         PAGE_BITS  = 13,
   parameter int         BANK_W     = 8,
   parameter int         NUM_IRQ    = 3,
   parameter int         SEL_W      = 3,
   parameter logic [7:0] SAVE_BANK  = 8'hF7,
   parameter int         SAVE_BYTES = 2048
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        map_we,
   input logic [SEL_W-1:0]            map_wsel,
   input logic [BANK_W-1:0]           map_wdata,
   input logic [SEL_W-1:0]            map_rsel,
   input logic [BANK_W-1:0]           map_rdata,
   input logic [LOG_AW-1:0]           acc_addr,
   input logic                        acc_rd,
   input logic                        acc_wr,
   input logic [BANK_W+PAGE_BITS-1:0] mem_addr,
   input logic                        mem_rd,
   input logic                        mem_wr,
   input logic                        io_rd,
   input logic                        io_wr,
   input logic [NUM_IRQ-1:0]          irq_set,
   input logic [NUM_IRQ-1:0]          irq_disable,
   input logic [NUM_IRQ-1:0]          irq_pending
);
   localparam int PHYS_W = BANK_W + PAGE_BITS;

   // R3: an I/O access never also drives the memory port
   p_io_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd || io_wr) |-> (!mem_rd && !mem_wr));

   // R4: save-bank writes stay inside the low window
   p_save_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mem_addr[PHYS_W-1 -: BANK_W] == BANK_W'(SAVE_BANK))
      |-> ({1'b0, mem_addr[PAGE_BITS-1:0]} < (PAGE_BITS+1)'(SAVE_BYTES)));

   // R1: memory offset is the logical offset
   p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (mem_addr[PAGE_BITS-1:0] == acc_addr[PAGE_BITS-1:0]));

   // R5: no memory write without a write strobe
   p_wr_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> acc_wr);

   // R2: a loaded register reads back its new value
   p_map_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      map_we |=> ((map_rsel != $past(map_wsel)) || (map_rdata == $past(map_wdata))));

   // R6: a set source is pending or masked on the next cycle
   p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_set != '0) |=> (((irq_pending | irq_disable) & $past(irq_set)) == $past(irq_set)));

   // R6: a disabled source is never pending
   p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_pending & irq_disable) == '0));
endmodule

bind page_xlate_unit pxu_checker #(
   .LOG_AW     (LOG_AW),
   .PAGE_BITS  (PAGE_BITS),
   .BANK_W     (BANK_W),
   .NUM_IRQ    (NUM_IRQ),
   .SEL_W      (SEL_W),
   .SAVE_BANK  (SAVE_BANK),
   .SAVE_BYTES (SAVE_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .map_we      (map_we),
   .map_wsel    (map_wsel),
   .map_wdata   (map_wdata),
   .map_rsel    (map_rsel),
   .map_rdata   (map_rdata),
   .acc_addr    (acc_addr),
   .acc_rd      (acc_rd),
   .acc_wr      (acc_wr),
   .mem_addr    (mem_addr),
   .mem_rd      (mem_rd),
   .mem_wr      (mem_wr),
   .io_rd       (io_rd),
   .io_wr       (io_wr),
   .irq_set     (irq_set),
   .irq_disable (irq_disable),
   .irq_pending (irq_pending)
);

// File: tb/page_xlate_unit_test.sv
`timescale 1ns/1ps
module page_xlate_unit_test;
   localparam logic [7:0] MEM_RD_V = 8'hC3;
   localparam logic [7:0] IO_RD_V  = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_we = 1'b0;
   logic [2:0]  map_wsel = '0;
   logic [7:0]  map_wdata = '0;
   logic [2:0]  map_rsel = '0;
   logic [7:0]  map_rdata;
   logic        wp_we = 1'b0;
   logic [7:0]  wp_bank = '0;
   logic        wp_flag = 1'b0;
   logic        save_present = 1'b0;
   logic [15:0] acc_addr = '0;
   logic        acc_rd = 1'b0;
   logic        acc_wr = 1'b0;
   logic [7:0]  acc_wdata = '0;
   logic [7:0]  acc_rdata;
   logic [20:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata;
   logic [12:0] io_addr;
   logic        io_rd, io_wr;
   logic [7:0]  io_wdata;
   logic [2:0]  irq_set = '0, irq_clr = '0, irq_disable = '0;
   logic [1:0]  irq_qsel = '0;
   logic [2:0]  irq_pending;
   logic        irq_hit;

   always #2 clk = ~clk;

   page_xlate_unit uut (
      .clk(clk), .rst_n(rst_n),
      .map_we(map_we), .map_wsel(map_wsel), .map_wdata(map_wdata),
      .map_rsel(map_rsel), .map_rdata(map_rdata),
      .wp_we(wp_we), .wp_bank(wp_bank), .wp_flag(wp_flag),
      .save_present(save_present),
      .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(MEM_RD_V),
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(IO_RD_V),
      .irq_set(irq_set), .irq_clr(irq_clr), .irq_disable(irq_disable),
      .irq_qsel(irq_qsel), .irq_pending(irq_pending), .irq_hit(irq_hit)
   );

   typedef struct {
      int          id;
      string       req;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   int    n_checks = 0;
   int    n_errors = 0;
   event  chk_ev;
   bit    done = 1'b0;

   logic [7:0] mdl_map [8];
   bit         mdl_wt [256];
   logic [2:0] mdl_act;

   function automatic logic [31:0] observe(int id);
      case (id)
         0: return 32'(mem_addr);
         1: return 32'(mem_rd);
         2: return 32'(mem_wr);
         3: return 32'(io_addr);
         4: return 32'(io_rd);
         5: return 32'(io_wr);
         6: return 32'(acc_rdata);
         7: return 32'(map_rdata);
         8: return 32'(irq_pending);
         9: return 32'(irq_hit);
         10: return 32'(mem_wdata);
         default: return 32'(io_wdata);
      endcase
   endfunction

   task automatic push(int id, string req, logic [31:0] exp);
      item_t it;
      it.id = id; it.req = req; it.exp = exp;
      q.push_back(it);
   endtask

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = observe(it.id);
            n_checks++;
            if (act !== it.exp) begin
               n_errors++;
               $display("FAIL %s field %0d: actual %h expected %h", it.req, it.id, act, it.exp);
            end
         end
      end
   end

   task automatic flush();
      #1;
      -> chk_ev;
      #0.1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_map(int sel, logic [7:0] val);
      map_we = 1'b1; map_wsel = 3'(sel); map_wdata = val;
      tick();
      map_we = 1'b0;
      mdl_map[sel] = val;
   endtask

   task automatic load_wp(logic [7:0] bank, bit flag);
      wp_we = 1'b1; wp_bank = bank; wp_flag = flag;
      tick();
      wp_we = 1'b0;
      mdl_wt[bank] = flag;
   endtask

   task automatic access(logic [15:0] addr, bit rd, bit wr, logic [7:0] wd);
      logic [7:0]  bank;
      logic [12:0] off;
      bit          wok;
      acc_addr = addr; acc_rd = rd; acc_wr = wr; acc_wdata = wd;
      bank = mdl_map[addr[15:13]];
      off  = addr[12:0];
      if (bank == 8'hFF) begin
         push(4, "R3", 32'(rd));
         push(5, "R3", 32'(wr));
         push(3, "R3", 32'(off));
         push(1, "R3", 0);
         push(2, "R3", 0);
         push(6, "R3", 32'(IO_RD_V));
      end else begin
         if (bank == 8'hF7) wok = save_present && (off <= 13'h7FF);
         else               wok = mdl_wt[bank];
         push(0, "R1", 32'({bank, off}));
         push(1, "R8", 32'(rd));
         push(2, (bank == 8'hF7) ? "R4" : "R5", 32'(wr && wok));
         push(4, "R8", 0);
         push(5, "R8", 0);
         push(6, "R8", 32'(MEM_RD_V));
         push(10, "R8", 32'(wd));
      end
      flush();
      tick();
      acc_rd = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic check_map_all(string req);
      for (int i = 0; i < 8; i++) begin
         map_rsel = 3'(i);
         push(7, req, 32'(mdl_map[i]));
         flush();
      end
   endtask

   task automatic check_irq();
      logic [2:0] pend;
      pend = mdl_act & ~irq_disable;
      push(8, "R6", 32'(pend));
      for (int s = 0; s < 4; s++) begin
         irq_qsel = 2'(s);
         push(9, "R7", (s < 3) ? 32'(pend[s]) : 0);
         flush();
      end
   endtask

   task automatic irq_cycle(logic [2:0] s, logic [2:0] c);
      irq_set = s; irq_clr = c;
      tick();
      irq_set = '0; irq_clr = '0;
      mdl_act = (mdl_act & ~c) | s;
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      mdl_map[0] = 8'hFF;
      for (int i = 1; i < 8; i++) mdl_map[i] = 8'h00;
      for (int b = 0; b < 256; b++) mdl_wt[b] = 1'b0;
      mdl_act = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset values, R6 reset pending
      check_map_all("R2");
      check_irq();

      // R3 I/O bank visible at reset through page 0
      access(16'h0123, 1, 0, 8'h00);
      access(16'h1FFF, 0, 1, 8'h5A);
      // R5 bank 0 not writable after reset
      access(16'h2345, 0, 1, 8'h11);

      // R2 loading the map registers
      load_map(1, 8'h10);
      load_map(2, 8'hF7);
      load_map(3, 8'h80);
      load_map(4, 8'hFF);
      load_map(7, 8'h01);
      check_map_all("R2");

      // R5 writable table
      load_wp(8'h10, 1'b1);
      access(16'h2456, 0, 1, 8'hA1);   // bank 0x10 writable
      access(16'h6456, 0, 1, 8'hA2);   // bank 0x80 read-only
      access(16'h6456, 1, 0, 8'h00);   // R8 read of read-only bank
      load_wp(8'h10, 1'b0);
      access(16'h2456, 0, 1, 8'hA3);

      // R4 save bank boundaries
      load_wp(8'hF7, 1'b1);            // the table does not open the save bank
      access(16'h4000, 0, 1, 8'hB0);
      save_present = 1'b1;
      access(16'h4000, 0, 1, 8'hB1);
      access(16'h47FF, 0, 1, 8'hB2);
      access(16'h4800, 0, 1, 8'hB3);
      access(16'h5FFF, 0, 1, 8'hB4);
      access(16'h5FFF, 1, 0, 8'h00);   // R8 full-offset read in save bank
      access(16'h8ABC, 0, 1, 8'hC0);   // page 4 -> I/O

      // R1 random traffic across all pages
      load_wp(8'h01, 1'b1);
      for (int k = 0; k < 300; k++) begin
         logic [15:0] a;
         bit w;
         a = 16'($urandom);
         w = ($urandom % 2) == 1;
         if (k % 50 == 0) save_present = ~save_present;
         access(a, !w, w, 8'($urandom));
      end

      // R6 / R7 interrupt bookkeeping
      irq_cycle(3'b001, 3'b000);
      check_irq();
      irq_disable = 3'b001;
      check_irq();
      irq_disable = 3'b000;
      irq_cycle(3'b110, 3'b110);       // set wins over clear
      check_irq();
      irq_cycle(3'b000, 3'b011);
      check_irq();
      irq_disable = 3'b100;
      check_irq();
      irq_cycle(3'b000, 3'b100);
      irq_disable = 3'b000;
      check_irq();

      done = 1'b1;
      finish_run();
   end
endmodule